// File: doc/BRIEF.md
# Flying-Capacitor Voltage Delay Compensator

In a five-level clamped converter each phase leg has a flying capacitor whose voltage reaches the controller only after a fixed measurement delay, so the value on hand describes the capacitor as it was several samples ago. This block rebuilds an estimate of the present voltage for three phases at once. Each sample period it adds to the stale measurement the charge that the capacitor has taken since then. That charge is a gain times the sum of (slope sign × phase current) over the samples inside the delay window. The slope sign depends on the phase state that was applied during that sample.

Each phase keeps a shift register of its own signed increments, one entry for each sample of the window. A sample strobe does three things at once: it evaluates the sum held in that register, it pushes the present increment into the register, and it registers the saturated result. The result appears with a one-cycle valid pulse. A small two-state machine, `ST_IDLE` and `ST_EMIT`, drives the valid output. The strobe moves it from `ST_IDLE` to `ST_EMIT` and keeps it in `ST_EMIT` when strobes arrive back to back. A cycle with no strobe returns it to `ST_IDLE`. The gain is an unsigned fraction with 16 fractional bits. It is loaded through its own strobe.

Top module: `fcap_delay_comp`

## Requirements
- R1: After reset, `comp_valid` is 0, every lane of `comp_v` is 0, the gain holds `GAIN_RESET`, and every history entry is zero. The first strobe therefore returns the measured voltage unchanged.
- R2: `comp_valid` is 1 in exactly the cycle after each cycle in which `sample_stb` is 1, and it is 0 in every other cycle.
- R3: The slope sign is taken from the 3-bit phase state code. Codes 6 and 2 give +1. Codes 5 and 1 give −1. Codes 0, 3, 4 and 7 give 0.
- R4: On a strobe the compensation term is built from the increments of the previous `DEPTH` strobes (default 3). The present current and state only enter the history and affect later results. Increments older than `DEPTH` strobes are dropped.
- R5: Each phase lane uses only its own measurement, current and state history. Lane p sits at bits [16p+15:16p], or [3p+2:3p] for states.
- R6: The compensated value is measured + floor((Σ slope·current) × gain / 2^16), with the gain taken as unsigned.
- R7: When the result exceeds the signed 16-bit range it is clamped to 32767 or −32768.
- R8: When `gain_load` is 1, `gain_in` becomes the gain for later strobes. A strobe in the same cycle still uses the old gain.
- R9: Without a strobe, `comp_v` and the history hold their values.
- R10: The state machine moves from `ST_IDLE` to `ST_EMIT` on a strobe, stays in `ST_EMIT` on a strobe, and goes from `ST_EMIT` to `ST_IDLE` without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | Sample strobe, one cycle per sample period |
| gain_load | input | 1 | Load `gain_in` into the gain register |
| gain_in | input | 16 | Unsigned gain, 16 fractional bits |
| meas_v | input | 48 | Delayed measured capacitor voltages, signed, 16 bits per phase |
| phase_cur | input | 48 | Present phase currents, signed, 16 bits per phase |
| phase_st | input | 9 | Applied phase state codes, 3 bits per phase |
| comp_v | output | 48 | Compensated voltages, signed, 16 bits per phase |
| comp_valid | output | 1 | High for one cycle after each strobe |

## Verification
Two of the block's functions can fall in the same cycle. The first case is a gain load in the same cycle as a sample strobe. The bench provokes it by raising both strobes together, and it judges the outcome by the rule that the result of that strobe is scaled by the old gain while the next strobe uses the new one. The second case is a strobe arriving while the machine is already in `ST_EMIT`. The bench drives strobes in consecutive cycles and expects `comp_valid` to stay high, with a fresh, correctly windowed value in each of those cycles.

// File: rtl/fcap_comp_pkg.sv
package fcap_comp_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_t;

    // Capacitor slope sign for positive current, keyed by phase state code.
    function automatic logic signed [1:0] slope_of(input logic [2:0] code);
        logic signed [1:0] s;
        unique case (code)
            3'd6, 3'd2: s = 2'sd1;
            3'd5, 3'd1: s = -2'sd1;
            default:    s = 2'sd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fcap_slope_term.sv
module fcap_slope_term #(
    parameter int DW = 16
) (
    input  logic [2:0]           state_code,
    input  logic signed [DW-1:0] cur,
    output logic signed [DW:0]   term
);
    import fcap_comp_pkg::*;

    logic signed [1:0] sgn;
    logic signed [DW:0] cur_x;

    always_comb begin
        sgn   = slope_of(state_code);
        cur_x = {cur[DW-1], cur};
        if (sgn == 2'sd1)
            term = cur_x;
        else if (sgn == -2'sd1)
            term = -cur_x;
        else
            term = '0;
    end
endmodule

// File: rtl/fcap_history.sv
module fcap_history #(
    parameter int DW    = 16,
    parameter int DEPTH = 3,
    parameter int SW    = DW + 1 + $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift,
    input  logic signed [DW:0]   term_in,
    output logic signed [SW-1:0] window_sum
);
    logic signed [DW:0] hist [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
        end else if (shift) begin
            hist[0] <= term_in;
            for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
        end
    end

    always_comb begin
        window_sum = '0;
        for (int i = 0; i < DEPTH; i++)
            window_sum = window_sum + {{(SW-DW-1){hist[i][DW]}}, hist[i]};
    end

    // R9: history frozen between strobes
    assert_history_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(window_sum));
endmodule

// File: rtl/fcap_scale_sat.sv
module fcap_scale_sat #(
    parameter int DW   = 16,
    parameter int SW   = 19,
    parameter int GW   = 16,
    parameter int FRAC = 16
) (
    input  logic signed [SW-1:0] window_sum,
    input  logic [GW-1:0]        gain,
    input  logic signed [DW-1:0] meas,
    output logic signed [DW-1:0] result
);
    localparam int PW = SW + GW + 1;
    localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [PW-1:0] sum_x, gain_x, prod, scaled, total;

    always_comb begin
        sum_x  = {{(PW-SW){window_sum[SW-1]}}, window_sum};
        gain_x = {{(PW-GW){1'b0}}, gain};
        prod   = sum_x * gain_x;
        scaled = prod >>> FRAC;
        total  = scaled + {{(PW-DW){meas[DW-1]}}, meas};
        if (total > MAXV)
            result = {1'b0, {(DW-1){1'b1}}};
        else if (total < MINV)
            result = {1'b1, {(DW-1){1'b0}}};
        else
            result = total[DW-1:0];
    end
endmodule

// File: rtl/fcap_delay_comp.sv
module fcap_delay_comp #(
    parameter int              DW        = 16,
    parameter int              GW        = 16,
    parameter int              FRAC      = 16,
    parameter int              DEPTH     = 3,
    parameter int              PHASES    = 3,
    parameter logic [GW-1:0]   GAIN_RESET = 16'd1024
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sample_stb,
    input  logic                   gain_load,
    input  logic [GW-1:0]          gain_in,
    input  logic [PHASES*DW-1:0]   meas_v,
    input  logic [PHASES*DW-1:0]   phase_cur,
    input  logic [PHASES*3-1:0]    phase_st,
    output logic [PHASES*DW-1:0]   comp_v,
    output logic                   comp_valid
);
    import fcap_comp_pkg::*;

    localparam int SW = DW + 1 + $clog2(DEPTH);

    emit_state_t state_q, state_d;
    logic [GW-1:0] gain_q;
    logic [PHASES*DW-1:0] next_v;

    // Gain register: a load alongside a strobe affects only later strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gain_q <= GAIN_RESET;
        else if (gain_load)
            gain_q <= gain_in;
    end

    generate
        for (genvar p = 0; p < PHASES; p++) begin : g_lane
            logic signed [DW:0]   term;
            logic signed [SW-1:0] wsum;
            logic signed [DW-1:0] lane_out;

            fcap_slope_term #(.DW(DW)) u_term (
                .state_code (phase_st[p*3 +: 3]),
                .cur        (phase_cur[p*DW +: DW]),
                .term       (term)
            );

            fcap_history #(.DW(DW), .DEPTH(DEPTH), .SW(SW)) u_hist (
                .clk        (clk),
                .rst_n      (rst_n),
                .shift      (sample_stb),
                .term_in    (term),
                .window_sum (wsum)
            );

            fcap_scale_sat #(.DW(DW), .SW(SW), .GW(GW), .FRAC(FRAC)) u_scale (
                .window_sum (wsum),
                .gain       (gain_q),
                .meas       (meas_v[p*DW +: DW]),
                .result     (lane_out)
            );

            assign next_v[p*DW +: DW] = lane_out;
        end
    endgenerate

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sample_stb) state_d = ST_EMIT;
            ST_EMIT: if (!sample_stb) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        comp_valid = (state_q == ST_EMIT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            comp_v <= '0;
        else if (sample_stb)
            comp_v <= next_v;
    end

    // R2: one-cycle valid after each strobe
    assert_valid_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> comp_valid);
    // R10: no strobe returns the machine to idle
    assert_return_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> !comp_valid);
    // R9: output holds between strobes
    assert_output_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(comp_v));
    // R8: gain changes only on a load
    assert_gain_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gain_load |=> $stable(gain_q));
endmodule

// File: tb/tb_fcap_delay_comp.sv
module tb_fcap_delay_comp;
    localparam int DEPTH = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_stb = 1'b0;
    logic gain_load = 1'b0;
    logic [15:0] gain_in = '0;
    logic [47:0] meas_v, phase_cur;
    logic [8:0]  phase_st;
    logic [47:0] comp_v;
    logic        comp_valid;

    logic signed [15:0] m [3];
    logic signed [15:0] c [3];
    logic [2:0]         s [3];

    always #2.5 clk = ~clk;

    always_comb begin
        for (int p = 0; p < 3; p++) begin
            meas_v[p*16 +: 16]   = m[p];
            phase_cur[p*16 +: 16] = c[p];
            phase_st[p*3 +: 3]   = s[p];
        end
    end

    fcap_delay_comp dut (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .gain_load(gain_load),
        .gain_in(gain_in), .meas_v(meas_v), .phase_cur(phase_cur), .phase_st(phase_st),
        .comp_v(comp_v), .comp_valid(comp_valid)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    longint mhist [3][DEPTH];
    longint mgain;
    longint expv [3];

    function automatic longint sgn_of(input logic [2:0] code);
        if (code == 3'd6 || code == 3'd2) return 1;
        if (code == 3'd5 || code == 3'd1) return -1;
        return 0;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sample_stb = 0; gain_load = 0;
        for (int p = 0; p < 3; p++) begin m[p] = 0; c[p] = 0; s[p] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mgain = 1024;
        for (int p = 0; p < 3; p++) for (int i = 0; i < DEPTH; i++) mhist[p][i] = 0;
    endtask

    // One strobe; called at a falling edge, returns at the next falling edge.
    task automatic step(input string req, input int mv0, input int mv1, input int mv2,
                        input int cu0, input int cu1, input int cu2,
                        input int st0, input int st1, input int st2,
                        input bit load, input int gval);
        longint sum, v;
        m[0] = 16'(mv0); m[1] = 16'(mv1); m[2] = 16'(mv2);
        c[0] = 16'(cu0); c[1] = 16'(cu1); c[2] = 16'(cu2);
        s[0] = 3'(st0);  s[1] = 3'(st1);  s[2] = 3'(st2);
        gain_load = load; gain_in = 16'(gval);
        sample_stb = 1'b1;
        for (int p = 0; p < 3; p++) begin
            sum = 0;
            for (int i = 0; i < DEPTH; i++) sum += mhist[p][i];
            v = longint'(m[p]) + ((sum * mgain) >>> 16);
            if (v > 32767) v = 32767;
            if (v < -32768) v = -32768;
            expv[p] = v;
            for (int i = DEPTH - 1; i > 0; i--) mhist[p][i] = mhist[p][i-1];
            mhist[p][0] = sgn_of(s[p]) * longint'(c[p]);
        end
        if (load) mgain = gval;
        @(posedge clk);
        @(negedge clk);
        sample_stb = 1'b0; gain_load = 1'b0;
        check({req, " valid"}, longint'(comp_valid), 1);
        for (int p = 0; p < 3; p++)
            check(req, longint'($signed(comp_v[p*16 +: 16])), expv[p]);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 valid", longint'(comp_valid), 0);
        check("R1 comp_v", longint'(comp_v), 0);
        step("R1 first strobe", 123, -456, 789, 1000, 2000, 3000, 6, 5, 2, 0, 0);
    endtask

    task automatic t_slope_codes();
        for (int code = 0; code < 8; code++) begin
            do_reset();
            step("R3 load", 0, 0, 0, 1000, -1000, 0, code, code, code, 1, 32768);
            step("R3 slope", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        end
    endtask

    task automatic t_window();
        do_reset();
        step("R4 w1", 10, 20, 30, 4000, 300, -700, 6, 1, 2, 1, 40000);
        step("R4 w2", 11, 21, 31, -900, 5000, 1200, 2, 6, 5, 0, 0);
        step("R4 w3", 12, 22, 32, 2500, -2500, 800, 5, 2, 3, 0, 0);
        step("R4 w4", -13, 23, -33, 100, 200, 300, 1, 4, 6, 0, 0);
        step("R4 drop", 14, -24, 34, 0, 0, 0, 7, 0, 4, 0, 0);
        step("R5 lanes", 500, -500, 0, 30000, -30000, 12345, 6, 6, 1, 0, 0);
        step("R6 scale", -1000, 1000, 7, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_saturate();
        do_reset();
        step("R7 fill", 0, 0, 0, 32767, 32767, -32768, 6, 5, 2, 1, 65535);
        step("R7 fill", 0, 0, 0, 32767, 32767, -32768, 6, 5, 2, 0, 0);
        step("R7 fill", 0, 0, 0, 32767, 32767, -32768, 6, 5, 2, 0, 0);
        step("R7 clamp", 32000, -32000, 100, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_gain_overlap();
        do_reset();
        step("R8 prep", 0, 0, 0, 8000, 8000, 8000, 6, 6, 6, 0, 0);
        step("R8 old gain", 5, 5, 5, 0, 0, 0, 0, 0, 0, 1, 60000);
        step("R8 new gain", 5, 5, 5, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_idle_hold();
        logic [47:0] held;
        do_reset();
        step("R9 prep", 100, 200, 300, 3000, 3000, 3000, 2, 1, 6, 0, 0);
        held = comp_v;
        c[0] = 16'sd9999; s[0] = 3'd6;
        repeat (4) begin
            @(negedge clk);
            check("R2 valid low", longint'(comp_valid), 0);
            check("R9 hold", longint'(comp_v), longint'(held));
        end
        step("R9 history", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_back_to_back();
        do_reset();
        step("R10 b2b", 1, 2, 3, 700, 800, 900, 6, 5, 2, 1, 50000);
        step("R10 b2b", 4, 5, 6, 1700, 1800, 1900, 2, 6, 1, 0, 0);
        step("R10 b2b", 7, 8, 9, -700, -800, -900, 5, 2, 6, 0, 0);
        @(negedge clk);
        check("R10 idle", longint'(comp_valid), 0);
    endtask

    initial begin
        t_reset();
        t_slope_codes();
        t_window();
        t_saturate();
        t_gain_overlap();
        t_idle_hold();
        t_back_to_back();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule